// File: doc/BRIEF.md
# Squash Request Filter and Redirect

This block sits at the retirement end of an out-of-order pipeline and runs separately for each hardware thread. Three sources can ask for a squash. The first is a delayed trap that follows a fault or interrupt. The second is an external thread-context request. The third is the execute stage, which reports a mispredicted branch or a replay.

Each cycle the block chooses which request takes effect. It throws away execute requests that are younger than the oldest squash point already in force. It then sends one squash message back toward the front end. The message carries the committed-boundary sequence number, the sequence number the reorder buffer should squash after, a redirect PC and branch-outcome information.

Once a squash is issued, the thread stays in a flushing state until the reorder buffer reports that its walk is finished. While it flushes, the squashing indication is repeated every cycle. The block also keeps the youngest still-valid sequence number, which is updated by reorder-buffer inserts, and a wrapping count of accepted mispredicts.

Top module: `squash_redirect`

## Requirements
- R1: After reset each thread is running. Every output is zero: no message, no squashing or trap indication, a youngest sequence of 0 and a mispredict count of 0.
- R2: `fault_take` is taken only in a running thread that issues no squash in the same cycle; otherwise it is ignored. If the request is sampled at edge k, `trap_pending` is high from edge k, and a whole-thread flush message is issued at edge k+TRAP_LAT.
- R3: A whole-thread flush (trap or context) sets both boundaries to `rob_head_seq`-1, or to 0 when `rob_empty` is high. It sets `sq_pc` to `commit_pc`, clears `sq_mispc`, `sq_mispred` and `sq_taken`, and clears the youngest sequence to 0.
- R4: A trap firing takes priority over a context request. If both arrive in the same cycle, one flush is issued, `sq_conflict` pulses with it, and the context request is dropped. A context request while a trap is pending flushes at once and cancels the trap countdown.
- R5: An execute request is accepted only when the thread is not trap-pending and `exe_seq` is less than or equal to the youngest sequence. A rejected request issues no message and leaves all state unchanged.
- R6: The base boundary is `exe_seq`, or `exe_seq`-1 when `exe_incl` is high. It is sent as `sq_done_seq` and becomes the new youngest sequence.
- R7: `sq_rob_seq` equals the base boundary plus one when both `exe_mispred` and `exe_keep_slot` are high. Otherwise it equals the base boundary.
- R8: An accepted execute message carries `exe_npc` as `sq_pc`, together with `exe_mispc`, `exe_mispred` and `exe_taken`.
- R9: A whole-thread flush in the same cycle as an execute request wins. The execute request has no effect on the message, the youngest sequence or the counter.
- R10: `rob_squashing` is high from the edge that issues a squash until an edge that samples `rob_done` high with no new squash.
- R11: `mispred_count` goes up by one, wrapping, for each accepted execute squash that has `exe_mispred` high.
- R12: When `ins_valid` is high, the thread is not flushing and no squash is issued, the youngest sequence takes the value of `ins_seq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_take | input | NUM_THREADS | Fault or interrupt taken, starts the trap delay |
| ctx_req | input | NUM_THREADS | Thread-context flush request |
| exe_req | input | NUM_THREADS | Execute-stage squash request |
| exe_seq | input | NUM_THREADS*SEQ_W | Sequence number of the squashing instruction |
| exe_incl | input | NUM_THREADS | Also squash the reporting instruction |
| exe_mispred | input | NUM_THREADS | Request is a branch mispredict |
| exe_taken | input | NUM_THREADS | Resolved branch direction |
| exe_keep_slot | input | NUM_THREADS | Keep the delay slot on a mispredict |
| exe_npc | input | NUM_THREADS*PC_W | Redirect PC from execute |
| exe_mispc | input | NUM_THREADS*PC_W | PC of the mispredicted branch |
| ins_valid | input | NUM_THREADS | Reorder-buffer insert this cycle |
| ins_seq | input | NUM_THREADS*SEQ_W | Sequence number of the insert |
| rob_empty | input | NUM_THREADS | Reorder buffer holds nothing for the thread |
| rob_head_seq | input | NUM_THREADS*SEQ_W | Sequence number at the buffer head |
| rob_done | input | NUM_THREADS | Reorder-buffer squash walk finished |
| commit_pc | input | NUM_THREADS*PC_W | Current committed PC of the thread |
| sq_valid | output | NUM_THREADS | One-cycle squash message strobe |
| sq_done_seq | output | NUM_THREADS*SEQ_W | Committed-boundary sequence number |
| sq_rob_seq | output | NUM_THREADS*SEQ_W | Reorder-buffer squash boundary |
| sq_pc | output | NUM_THREADS*PC_W | Redirect PC |
| sq_mispc | output | NUM_THREADS*PC_W | Mispredicted branch PC |
| sq_mispred | output | NUM_THREADS | Message is a mispredict |
| sq_taken | output | NUM_THREADS | Branch direction in the message |
| sq_conflict | output | NUM_THREADS | Trap and context flush collided |
| rob_squashing | output | NUM_THREADS | Thread is flushing |
| trap_pending | output | NUM_THREADS | Trap delay running |
| youngest_seq | output | NUM_THREADS*SEQ_W | Youngest still-valid sequence number |
| mispred_count | output | NUM_THREADS*CNT_W | Accepted mispredict count |

## Verification
Every message field, `sq_conflict`, `rob_squashing`, the youngest sequence and the counter come from registers. Each is therefore due on the first edge that samples its request. The one exception is the trap flush, which is due exactly TRAP_LAT edges after the `fault_take` edge. The bench drives inputs after a falling edge and steps a behavioural model on the rising edge. It compares every output at the next falling edge, so each comparison looks at the cycle in which the result must appear. Directed checks count the trap delay edge by edge and sample the cycle before the flush as well as the flush cycle.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  // Per-thread retirement-side state
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_TRAP  = 2'd1,
    MODE_FLUSH = 2'd2
  } sqr_mode_e;
endpackage

// File: rtl/sqr_trap_timer.sv
module sqr_trap_timer #(
  parameter int TRAP_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic fire
);
  localparam int TW = $clog2(TRAP_LAT + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cancel)                cnt_d = '0;
    else if (start)            cnt_d = TW'(TRAP_LAT);
    else if (cnt_q != '0)      cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire = (cnt_q == TW'(1));
endmodule

// File: rtl/sqr_thread_ctl.sv
module sqr_thread_ctl
  import sqr_pkg::*;
#(
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32,
  parameter int CNT_W    = 8,
  parameter int TRAP_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_take,
  input  logic             ctx_req,
  input  logic             exe_req,
  input  logic [SEQ_W-1:0] exe_seq,
  input  logic             exe_incl,
  input  logic             exe_mispred,
  input  logic             exe_taken,
  input  logic             exe_keep_slot,
  input  logic [PC_W-1:0]  exe_npc,
  input  logic [PC_W-1:0]  exe_mispc,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] rob_head_seq,
  input  logic             rob_done,
  input  logic [PC_W-1:0]  commit_pc,
  output logic             sq_valid,
  output logic [SEQ_W-1:0] sq_done_seq,
  output logic [SEQ_W-1:0] sq_rob_seq,
  output logic [PC_W-1:0]  sq_pc,
  output logic [PC_W-1:0]  sq_mispc,
  output logic             sq_mispred,
  output logic             sq_taken,
  output logic             sq_conflict,
  output logic             rob_squashing,
  output logic             trap_pending,
  output logic [SEQ_W-1:0] youngest_seq,
  output logic [CNT_W-1:0] mispred_count
);
  sqr_mode_e        mode_q, mode_d;
  logic [SEQ_W-1:0] young_q, young_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic             fire, flush, exe_ok, fault_ok, issue;
  logic [SEQ_W-1:0] base_seq, whole_seq;

  logic             msg_v_q, conf_q, mp_q, tk_q;
  logic [SEQ_W-1:0] done_q, robb_q, done_d, robb_d;
  logic [PC_W-1:0]  pc_q, mispc_q, pc_d, mispc_d;
  logic             mp_d, tk_d;

  sqr_trap_timer #(.TRAP_LAT(TRAP_LAT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fault_ok),
    .cancel(ctx_req),
    .fire  (fire)
  );

  // Request selection: trap/context flush first, then execute, then fault
  always_comb begin
    flush     = fire | ctx_req;
    exe_ok    = exe_req && (mode_q != MODE_TRAP) && (exe_seq <= young_q) && !flush;
    issue     = flush | exe_ok;
    fault_ok  = fault_take && (mode_q == MODE_RUN) && !issue;
    base_seq  = exe_incl ? (exe_seq - SEQ_W'(1)) : exe_seq;
    whole_seq = rob_empty ? '0 : (rob_head_seq - SEQ_W'(1));
  end

  // Next-state logic
  always_comb begin
    mode_d = mode_q;
    if (mode_q == MODE_FLUSH && rob_done) mode_d = MODE_RUN;
    if (fault_ok)                         mode_d = MODE_TRAP;
    if (issue)                            mode_d = MODE_FLUSH;

    young_d = young_q;
    if (flush)                                    young_d = '0;
    else if (exe_ok)                              young_d = base_seq;
    else if (ins_valid && mode_q != MODE_FLUSH)   young_d = ins_seq;

    cnt_d = cnt_q + CNT_W'(exe_ok && exe_mispred);

    if (flush) begin
      done_d  = whole_seq;
      robb_d  = whole_seq;
      pc_d    = commit_pc;
      mispc_d = '0;
      mp_d    = 1'b0;
      tk_d    = 1'b0;
    end else begin
      done_d  = base_seq;
      robb_d  = base_seq + SEQ_W'(exe_mispred && exe_keep_slot);
      pc_d    = exe_npc;
      mispc_d = exe_mispc;
      mp_d    = exe_mispred;
      tk_d    = exe_taken;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RUN;
      young_q <= '0;
      cnt_q   <= '0;
      msg_v_q <= 1'b0;
      conf_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      young_q <= young_d;
      cnt_q   <= cnt_d;
      msg_v_q <= issue;
      conf_q  <= fire & ctx_req;
    end
  end

  // Message payload, loaded only when a squash issues
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= '0;
      robb_q  <= '0;
      pc_q    <= '0;
      mispc_q <= '0;
      mp_q    <= 1'b0;
      tk_q    <= 1'b0;
    end else if (issue) begin
      done_q  <= done_d;
      robb_q  <= robb_d;
      pc_q    <= pc_d;
      mispc_q <= mispc_d;
      mp_q    <= mp_d;
      tk_q    <= tk_d;
    end
  end

  assign sq_valid      = msg_v_q;
  assign sq_done_seq   = done_q;
  assign sq_rob_seq    = robb_q;
  assign sq_pc         = pc_q;
  assign sq_mispc      = mispc_q;
  assign sq_mispred    = mp_q;
  assign sq_taken      = tk_q;
  assign sq_conflict   = conf_q;
  assign rob_squashing = (mode_q == MODE_FLUSH);
  assign trap_pending  = (mode_q == MODE_TRAP);
  assign youngest_seq  = young_q;
  assign mispred_count = cnt_q;
endmodule

// File: rtl/squash_redirect.sv
module squash_redirect #(
  parameter int NUM_THREADS = 2,
  parameter int SEQ_W       = 16,
  parameter int PC_W        = 32,
  parameter int CNT_W       = 8,
  parameter int TRAP_LAT    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_THREADS-1:0]       fault_take,
  input  logic [NUM_THREADS-1:0]       ctx_req,
  input  logic [NUM_THREADS-1:0]       exe_req,
  input  logic [NUM_THREADS*SEQ_W-1:0] exe_seq,
  input  logic [NUM_THREADS-1:0]       exe_incl,
  input  logic [NUM_THREADS-1:0]       exe_mispred,
  input  logic [NUM_THREADS-1:0]       exe_taken,
  input  logic [NUM_THREADS-1:0]       exe_keep_slot,
  input  logic [NUM_THREADS*PC_W-1:0]  exe_npc,
  input  logic [NUM_THREADS*PC_W-1:0]  exe_mispc,
  input  logic [NUM_THREADS-1:0]       ins_valid,
  input  logic [NUM_THREADS*SEQ_W-1:0] ins_seq,
  input  logic [NUM_THREADS-1:0]       rob_empty,
  input  logic [NUM_THREADS*SEQ_W-1:0] rob_head_seq,
  input  logic [NUM_THREADS-1:0]       rob_done,
  input  logic [NUM_THREADS*PC_W-1:0]  commit_pc,
  output logic [NUM_THREADS-1:0]       sq_valid,
  output logic [NUM_THREADS*SEQ_W-1:0] sq_done_seq,
  output logic [NUM_THREADS*SEQ_W-1:0] sq_rob_seq,
  output logic [NUM_THREADS*PC_W-1:0]  sq_pc,
  output logic [NUM_THREADS*PC_W-1:0]  sq_mispc,
  output logic [NUM_THREADS-1:0]       sq_mispred,
  output logic [NUM_THREADS-1:0]       sq_taken,
  output logic [NUM_THREADS-1:0]       sq_conflict,
  output logic [NUM_THREADS-1:0]       rob_squashing,
  output logic [NUM_THREADS-1:0]       trap_pending,
  output logic [NUM_THREADS*SEQ_W-1:0] youngest_seq,
  output logic [NUM_THREADS*CNT_W-1:0] mispred_count
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    sqr_thread_ctl #(
      .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W), .TRAP_LAT(TRAP_LAT)
    ) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .fault_take   (fault_take[t]),
      .ctx_req      (ctx_req[t]),
      .exe_req      (exe_req[t]),
      .exe_seq      (exe_seq[t*SEQ_W +: SEQ_W]),
      .exe_incl     (exe_incl[t]),
      .exe_mispred  (exe_mispred[t]),
      .exe_taken    (exe_taken[t]),
      .exe_keep_slot(exe_keep_slot[t]),
      .exe_npc      (exe_npc[t*PC_W +: PC_W]),
      .exe_mispc    (exe_mispc[t*PC_W +: PC_W]),
      .ins_valid    (ins_valid[t]),
      .ins_seq      (ins_seq[t*SEQ_W +: SEQ_W]),
      .rob_empty    (rob_empty[t]),
      .rob_head_seq (rob_head_seq[t*SEQ_W +: SEQ_W]),
      .rob_done     (rob_done[t]),
      .commit_pc    (commit_pc[t*PC_W +: PC_W]),
      .sq_valid     (sq_valid[t]),
      .sq_done_seq  (sq_done_seq[t*SEQ_W +: SEQ_W]),
      .sq_rob_seq   (sq_rob_seq[t*SEQ_W +: SEQ_W]),
      .sq_pc        (sq_pc[t*PC_W +: PC_W]),
      .sq_mispc     (sq_mispc[t*PC_W +: PC_W]),
      .sq_mispred   (sq_mispred[t]),
      .sq_taken     (sq_taken[t]),
      .sq_conflict  (sq_conflict[t]),
      .rob_squashing(rob_squashing[t]),
      .trap_pending (trap_pending[t]),
      .youngest_seq (youngest_seq[t*SEQ_W +: SEQ_W]),
      .mispred_count(mispred_count[t*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/squash_redirect_chk.sv
module squash_redirect_chk #(
  parameter int NUM_THREADS = 2,
  parameter int CNT_W       = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_THREADS-1:0]       sq_valid,
  input logic [NUM_THREADS-1:0]       sq_conflict,
  input logic [NUM_THREADS-1:0]       sq_mispred,
  input logic [NUM_THREADS-1:0]       rob_squashing,
  input logic [NUM_THREADS-1:0]       trap_pending,
  input logic [NUM_THREADS*CNT_W-1:0] mispred_count
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    // R10
    issue_sets_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sq_valid[t] |-> rob_squashing[t]);

    // R2
    trap_flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_pending[t] && rob_squashing[t]));

    // R2
    trap_exit_by_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pending[t] |=> (trap_pending[t] || sq_valid[t]));

    // R4
    conflict_with_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sq_conflict[t] |-> (sq_valid[t] && !sq_mispred[t]));

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mispred_count[t*CNT_W +: CNT_W] == $past(mispred_count[t*CNT_W +: CNT_W]) ||
                mispred_count[t*CNT_W +: CNT_W] == $past(mispred_count[t*CNT_W +: CNT_W]) + CNT_W'(1)));

    // R11
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_valid[t] && !sq_mispred[t]) |->
        mispred_count[t*CNT_W +: CNT_W] == $past(mispred_count[t*CNT_W +: CNT_W]));
  end
endmodule

bind squash_redirect squash_redirect_chk #(
  .NUM_THREADS(NUM_THREADS),
  .CNT_W      (CNT_W)
) u_chk (.*);

// File: tb/squash_redirect_bench.sv
module squash_redirect_bench;
  localparam int T  = 2;
  localparam int S  = 16;
  localparam int P  = 32;
  localparam int C  = 8;
  localparam int TL = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [T-1:0]   fault_take, ctx_req, exe_req, exe_incl, exe_mispred, exe_taken, exe_keep_slot;
  logic [T-1:0]   ins_valid, rob_empty, rob_done;
  logic [T*S-1:0] exe_seq, ins_seq, rob_head_seq;
  logic [T*P-1:0] exe_npc, exe_mispc, commit_pc;
  logic [T-1:0]   sq_valid, sq_mispred, sq_taken, sq_conflict, rob_squashing, trap_pending;
  logic [T*S-1:0] sq_done_seq, sq_rob_seq, youngest_seq;
  logic [T*P-1:0] sq_pc, sq_mispc;
  logic [T*C-1:0] mispred_count;

  squash_redirect #(.NUM_THREADS(T), .SEQ_W(S), .PC_W(P), .CNT_W(C), .TRAP_LAT(TL))
  u_squash_redirect (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Behavioural reference model: 0 running, 1 trap pending, 2 flushing
  int       m_mode[T];
  int       m_tmr[T];
  logic [S-1:0] m_young[T], e_done[T], e_robb[T];
  logic [P-1:0] e_pc[T], e_mispc[T];
  logic [C-1:0] m_cnt[T];
  logic         e_v[T], e_mp[T], e_tk[T], e_conf[T];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < T; t++) begin
        m_mode[t] = 0; m_tmr[t] = 0; m_young[t] = 0; m_cnt[t] = 0;
        e_done[t] = 0; e_robb[t] = 0; e_pc[t] = 0; e_mispc[t] = 0;
        e_v[t] = 0; e_mp[t] = 0; e_tk[t] = 0; e_conf[t] = 0;
      end
    end else begin
      for (int t = 0; t < T; t++) begin
        automatic int  old = m_mode[t];
        automatic bit  fire = (old == 1) && (m_tmr[t] == 1);
        automatic bit  fl = fire || ctx_req[t];
        automatic logic [S-1:0] sq = exe_seq[t*S +: S];
        automatic bit  ok = exe_req[t] && old != 1 && sq <= m_young[t] && !fl;
        automatic logic [S-1:0] base = exe_incl[t] ? sq - 1'b1 : sq;
        e_v[t] = fl || ok;
        e_conf[t] = fire && ctx_req[t];
        if (old == 2 && rob_done[t]) m_mode[t] = 0;
        if (old == 1 && !fire) m_tmr[t] = m_tmr[t] - 1;
        if (fl) begin
          m_tmr[t] = 0;
          e_done[t] = rob_empty[t] ? '0 : rob_head_seq[t*S +: S] - 1'b1;
          e_robb[t] = e_done[t];
          e_pc[t] = commit_pc[t*P +: P]; e_mispc[t] = 0; e_mp[t] = 0; e_tk[t] = 0;
          m_young[t] = 0; m_mode[t] = 2;
        end else if (ok) begin
          e_done[t] = base;
          e_robb[t] = (exe_mispred[t] && exe_keep_slot[t]) ? base + 1'b1 : base;
          e_pc[t] = exe_npc[t*P +: P]; e_mispc[t] = exe_mispc[t*P +: P];
          e_mp[t] = exe_mispred[t]; e_tk[t] = exe_taken[t];
          m_young[t] = base;
          if (exe_mispred[t]) m_cnt[t] = m_cnt[t] + 1'b1;
          m_mode[t] = 2;
        end else begin
          if (fault_take[t] && old == 0) begin m_mode[t] = 1; m_tmr[t] = TL; end
          if (ins_valid[t] && old != 2) m_young[t] = ins_seq[t*S +: S];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int t = 0; t < T; t++) begin
      chk("R5 sq_valid", sq_valid[t], e_v[t]);
      chk("R4 sq_conflict", sq_conflict[t], e_conf[t]);
      chk("R10 rob_squashing", rob_squashing[t], m_mode[t] == 2);
      chk("R2 trap_pending", trap_pending[t], m_mode[t] == 1);
      chk("R12 youngest_seq", youngest_seq[t*S +: S], m_young[t]);
      chk("R11 mispred_count", mispred_count[t*C +: C], m_cnt[t]);
      chk("R6 sq_done_seq", sq_done_seq[t*S +: S], e_done[t]);
      chk("R7 sq_rob_seq", sq_rob_seq[t*S +: S], e_robb[t]);
      chk("R8 sq_pc", sq_pc[t*P +: P], e_pc[t]);
      chk("R8 sq_mispc", sq_mispc[t*P +: P], e_mispc[t]);
      chk("R8 sq_mispred", sq_mispred[t], e_mp[t]);
      chk("R8 sq_taken", sq_taken[t], e_tk[t]);
    end
  endtask

  task automatic clr();
    fault_take = 0; ctx_req = 0; exe_req = 0; exe_incl = 0; exe_mispred = 0;
    exe_taken = 0; exe_keep_slot = 0; ins_valid = 0; rob_done = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; clr();
    exe_seq = '0; ins_seq = '0; rob_head_seq = '0; exe_npc = '0; exe_mispc = '0;
    commit_pc = '0; rob_empty = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 sq_valid", sq_valid, 0);
    chk("R1 rob_squashing", rob_squashing, 0);
    chk("R1 trap_pending", trap_pending, 0);
    chk("R1 youngest_seq", youngest_seq, 0);
    chk("R1 mispred_count", mispred_count, 0);
    compare_all();

    // R12 inserts track youngest
    for (int i = 10; i <= 13; i++) begin
      ins_valid[0] = 1; ins_seq[0 +: S] = S'(i); tick();
    end
    clr();
    chk("R12 youngest after inserts", youngest_seq[0 +: S], 13);

    // R7 mispredict keeping delay slot
    exe_req[0] = 1; exe_seq[0 +: S] = 12; exe_mispred[0] = 1; exe_keep_slot[0] = 1;
    exe_taken[0] = 1; exe_npc[0 +: P] = 32'h100; exe_mispc[0 +: P] = 32'h80;
    tick(); clr();
    chk("R7 rob boundary +1", sq_rob_seq[0 +: S], 13);
    chk("R6 done boundary", sq_done_seq[0 +: S], 12);
    chk("R11 count", mispred_count[0 +: C], 1);
    chk("R8 redirect pc", sq_pc[0 +: P], 32'h100);
    tick();
    chk("R10 still squashing", rob_squashing[0], 1);
    rob_done[0] = 1; tick(); clr();
    chk("R10 squashing ends", rob_squashing[0], 0);

    // R5 younger request rejected
    exe_req[0] = 1; exe_seq[0 +: S] = 20; exe_mispred[0] = 1; tick(); clr();
    chk("R5 younger rejected", sq_valid[0], 0);
    chk("R5 youngest kept", youngest_seq[0 +: S], 12);

    // R6 inclusive squash
    exe_req[0] = 1; exe_seq[0 +: S] = 11; exe_incl[0] = 1; tick(); clr();
    chk("R6 inclusive done", sq_done_seq[0 +: S], 10);
    chk("R7 no slot adjust", sq_rob_seq[0 +: S], 10);
    chk("R6 youngest set", youngest_seq[0 +: S], 10);
    rob_done[0] = 1; tick(); clr();

    // R2/R3 trap path with delayed flush
    rob_empty[0] = 0; rob_head_seq[0 +: S] = 7; commit_pc[0 +: P] = 32'h200;
    fault_take[0] = 1; tick(); clr();
    chk("R2 trap pending", trap_pending[0], 1);
    exe_req[0] = 1; exe_seq[0 +: S] = 1; tick(); clr();
    chk("R5 ignored in trap", sq_valid[0], 0);
    tick(); tick();
    chk("R2 not yet fired", sq_valid[0], 0);
    tick();
    chk("R2 fired", sq_valid[0], 1);
    chk("R3 head minus one", sq_done_seq[0 +: S], 6);
    chk("R3 commit pc", sq_pc[0 +: P], 32'h200);
    chk("R3 youngest cleared", youngest_seq[0 +: S], 0);
    rob_done[0] = 1; tick(); clr();

    // R3 context flush with empty buffer
    rob_empty[0] = 1; ctx_req[0] = 1; tick(); clr();
    chk("R3 empty boundary", sq_done_seq[0 +: S], 0);
    rob_done[0] = 1; tick(); clr();

    // R4 collision of trap and context request
    rob_empty[0] = 0; fault_take[0] = 1; tick(); clr();
    tick(); tick(); tick();
    ctx_req[0] = 1; tick(); clr();
    chk("R4 conflict flagged", sq_conflict[0], 1);
    chk("R4 single message", sq_valid[0], 1);
    tick();
    chk("R4 conflict pulse", sq_conflict[0], 0);
    chk("R4 no second flush", sq_valid[0], 0);
    rob_done[0] = 1; tick(); clr();

    // R9 flush beats execute
    ins_valid[0] = 1; ins_seq[0 +: S] = 30; tick(); clr();
    ctx_req[0] = 1; exe_req[0] = 1; exe_seq[0 +: S] = 5; exe_mispred[0] = 1; tick(); clr();
    chk("R9 no mispred", sq_mispred[0], 0);
    chk("R9 count unchanged", mispred_count[0 +: C], 1);
    chk("R9 youngest cleared", youngest_seq[0 +: S], 0);
    rob_done[0] = 1; tick(); clr();

    // R4 context request cancels trap countdown
    fault_take[0] = 1; tick(); clr();
    ctx_req[0] = 1; tick(); clr();
    chk("R4 ctx flush in trap", sq_valid[0], 1);
    tick(); tick(); tick(); tick();
    chk("R4 countdown cancelled", sq_valid[0], 0);
    rob_done[0] = 1; tick(); clr();

    // Mixed stimulus on both threads, compared against the model each cycle
    for (int c = 0; c < 3000; c++) begin
      for (int t = 0; t < T; t++) begin
        fault_take[t]    = ($urandom_range(0, 15) == 0);
        ctx_req[t]       = ($urandom_range(0, 31) == 0);
        exe_req[t]       = ($urandom_range(0, 5) == 0);
        exe_incl[t]      = $urandom_range(0, 1);
        exe_mispred[t]   = $urandom_range(0, 1);
        exe_taken[t]     = $urandom_range(0, 1);
        exe_keep_slot[t] = $urandom_range(0, 1);
        ins_valid[t]     = $urandom_range(0, 1);
        rob_empty[t]     = ($urandom_range(0, 3) == 0);
        rob_done[t]      = $urandom_range(0, 1);
        exe_seq[t*S +: S]      = S'($urandom_range(0, 40));
        ins_seq[t*S +: S]      = S'($urandom_range(0, 40));
        rob_head_seq[t*S +: S] = S'($urandom_range(0, 40));
        exe_npc[t*P +: P]      = $urandom;
        exe_mispc[t*P +: P]    = $urandom;
        commit_pc[t*P +: P]    = $urandom;
      end
      tick();
    end
    clr();
    tick();

    finished = 1;
    finish_run();
  end
endmodule